// File: doc/BRIEF.md
# Half-Warp Memory Request Coalescer

This block takes one memory request from a group of sixteen threads and breaks it into as few aligned memory transactions as it can. The request has three parts. The first is an activity mask with one bit for each thread. The second is a byte address for each thread. The third is one element size shared by all threads. The block answers with a run of transactions. Each transaction names an aligned base address, a length of 32, 64 or 128 bytes, and the set of threads it serves.

The block works one step at a time. At each step it picks the lowest-numbered thread that is still pending and finds the aligned segment that holds that thread's address. The segment length depends on the element size. Every pending thread whose address falls inside that segment is served by the transaction. After that the transaction is trimmed. If the served bytes touch only one half of a 128-byte window, the window drops to 64 bytes. If they touch only one half of a 64-byte window, it drops to 32 bytes. The served threads are then retired. Once no thread is left pending, the block raises a one-cycle done pulse and returns to idle.

Top module: `hw_coalescer`

## Requirements
- R1: After reset, req_ready is 1, txn_valid is 0 and done is 0. req_ready is 1 only while the block is idle. A request is taken on a clock edge where req_valid and req_ready are both 1. From that edge until done, req_ready stays 0.
- R2: Each transaction's mask includes the lowest-numbered thread still pending. Its window lies inside the segment that holds that thread's address.
- R3: The element size code req_esize is 0, 1, 2, 3 or 4, meaning 1, 2, 4, 8 or 16 bytes. The segment is 32 bytes for code 0, 64 bytes for code 1, and 128 bytes for codes 2 to 4. The segment base is the leader's address with its low log2(segment) bits cleared.
- R4: A transaction's mask is exactly the set of pending threads whose address lies in the leader's segment. Each of those threads is then retired. Over a whole request, every active thread is served exactly once.
- R5: A thread touches the bytes from its address up to its address plus the element size minus one. If the served threads touch only the lower or only the upper 64-byte half of a 128-byte segment, the transaction is 64 bytes long and sits on that half.
- R6: If the served threads touch only one 32-byte half of a 64-byte window, the transaction is 32 bytes long and sits on that half. The 64-byte window can be a native 64-byte segment or one already trimmed under R5.
- R7: txn_size is 0 for 32 bytes, 1 for 64 bytes and 2 for 128 bytes. txn_base is always aligned to the transaction length.
- R8: Threads that are inactive when the request is taken never appear in any transaction. A request with an empty mask issues no transaction and raises done in the first cycle after it is taken.
- R9: While txn_valid is 1 and txn_ready is 0, the transaction outputs hold steady. The next transaction follows only after a handshake. txn_valid stays 1 while any thread is pending.
- R10: done is high for exactly one cycle, in the cycle after the last handshake. The block is idle in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_mask | input | NTHR | Active thread mask of the request |
| req_addr | input | NTHR*AW | Byte address of each thread, thread i at bits [i*AW +: AW] |
| req_esize | input | 3 | Element size code (0..4 for 1..16 bytes) |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Downstream accepts the transaction |
| txn_base | output | AW | Aligned base address of the transaction |
| txn_size | output | 2 | Transaction length code (0:32, 1:64, 2:128 bytes) |
| txn_mask | output | NTHR | Threads served by the transaction |
| done | output | 1 | One-cycle pulse when the request is fully served |

## Verification
The assertions assume two things about each request that is taken. First, every active thread's address is a multiple of the element size. Second, the size code is no greater than 4. Together these keep each thread's byte range inside one segment. The stimulus meets both assumptions. It builds every address as an aligned base plus a multiple of the element size, and it only uses size codes 0 to 4. txn_ready follows a pseudo-random pattern, so stalls of different lengths are applied, and the hold rule is checked against them.

// File: rtl/coal_pkg.sv
// Shared types and helpers for the half-warp coalescer.
// Assumes element size codes 0..4 (1..16 bytes); larger codes are treated as 16 bytes.
package coal_pkg;

    typedef enum logic [1:0] {
        TSZ_32  = 2'd0,
        TSZ_64  = 2'd1,
        TSZ_128 = 2'd2
    } tsize_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    // Segment length picked by the element size code.
    function automatic tsize_e seg_of(input logic [2:0] esize);
        case (esize)
            3'd0:    return TSZ_32;
            3'd1:    return TSZ_64;
            default: return TSZ_128;
        endcase
    endfunction

    // Element size in bytes minus one.
    function automatic logic [6:0] ebytes_m1(input logic [2:0] esize);
        case (esize)
            3'd0:    return 7'd0;
            3'd1:    return 7'd1;
            3'd2:    return 7'd3;
            3'd3:    return 7'd7;
            default: return 7'd15;
        endcase
    endfunction

endpackage

// File: rtl/hw_coal_leader.sv
// Finds the lowest-numbered pending thread.
// Assumes nothing about the mask; when it is empty, idx is 0 and any is 0.
module hw_coal_leader #(
    parameter int NTHR = 16,
    localparam int IDXW = $clog2(NTHR)
) (
    input  logic [NTHR-1:0] pend,
    output logic [IDXW-1:0] idx,
    output logic            any
);

    // Priority scan from the top down, so the lowest set bit wins.
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = NTHR - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = IDXW'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/hw_coal_match.sv
// Finds the leader's segment, the pending threads inside it, and the
// 32-byte quarters (of a window of up to 128 bytes) that those threads touch.
// Assumes each address is aligned to the element size, so a thread's bytes
// never cross its segment.
module hw_coal_match
    import coal_pkg::*;
#(
    parameter int NTHR = 16,
    parameter int AW   = 32,
    localparam int IDXW = $clog2(NTHR)
) (
    input  logic [NTHR-1:0]    pend,
    input  logic [NTHR*AW-1:0] addr,
    input  logic [2:0]         esize,
    input  tsize_e             seg,
    input  logic [IDXW-1:0]    leader,
    output logic [NTHR-1:0]    served,
    output logic [AW-1:0]      seg_base,
    output logic [3:0]         qmask
);

    logic [7:0]    seg_bytes;
    logic [AW-1:0] keep;
    logic [6:0]    lowm;
    logic [6:0]    ebm1;
    logic [3:0]    tq [NTHR];

    // Byte length of the current segment.
    always_comb begin
        case (seg)
            TSZ_32:  seg_bytes = 8'd32;
            TSZ_64:  seg_bytes = 8'd64;
            default: seg_bytes = 8'd128;
        endcase
    end

    assign keep     = ~AW'(seg_bytes - 8'd1);
    assign lowm     = 7'(seg_bytes - 8'd1);
    assign ebm1     = ebytes_m1(esize);
    assign seg_base = addr[leader*AW +: AW] & keep;

    for (genvar i = 0; i < NTHR; i++) begin : g_thr
        logic [AW-1:0] a_i;
        logic [6:0]    lo_i;
        logic [6:0]    hi_i;
        assign a_i       = addr[i*AW +: AW];
        assign lo_i      = a_i[6:0] & lowm;
        assign hi_i      = lo_i + ebm1;
        assign served[i] = pend[i] && ((a_i & keep) == seg_base);
        for (genvar q = 0; q < 4; q++) begin : g_q
            assign tq[i][q] = served[i] && (lo_i[6:5] <= 2'(q)) && (hi_i[6:5] >= 2'(q));
        end
    end

    // Union of touched quarters over all served threads.
    always_comb begin
        qmask = 4'b0000;
        for (int i = 0; i < NTHR; i++) begin
            qmask = qmask | tq[i];
        end
    end

endmodule

// File: rtl/hw_coal_shrink.sv
// Trims a segment to the smallest legal window that covers the touched
// quarters: 128 to 64 bytes, then 64 to 32 bytes.
// Assumes qmask is not empty while a transaction is offered.
module hw_coal_shrink
    import coal_pkg::*;
#(
    parameter int AW = 32
) (
    input  tsize_e        seg,
    input  logic [AW-1:0] seg_base,
    input  logic [3:0]    qmask,
    output tsize_e        size,
    output logic [AW-1:0] base
);

    logic [6:0] woff;
    logic [1:0] pair;

    // Two-stage halving decision on the quarter usage.
    always_comb begin
        size = seg;
        woff = 7'd0;
        pair = 2'b00;
        if (seg == TSZ_128) begin
            if (qmask[3:2] == 2'b00) begin
                size = TSZ_64;
            end else if (qmask[1:0] == 2'b00) begin
                size = TSZ_64;
                woff = 7'd64;
            end
        end
        if (size == TSZ_64) begin
            pair = woff[6] ? qmask[3:2] : qmask[1:0];
            if (pair == 2'b01) begin
                size = TSZ_32;
            end else if (pair == 2'b10) begin
                size = TSZ_32;
                woff = woff + 7'd32;
            end
        end
    end

    assign base = seg_base + AW'(woff);

endmodule

// File: rtl/hw_coalescer.sv
// Half-warp memory request coalescer: takes one request while idle, then
// issues one aligned transaction per handshake until no thread is pending.
// Assumes active addresses are aligned to the element size and size code <= 4.
module hw_coalescer
    import coal_pkg::*;
#(
    parameter int NTHR = 16,
    parameter int AW   = 32,
    localparam int IDXW = $clog2(NTHR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [NTHR-1:0]    req_mask,
    input  logic [NTHR*AW-1:0] req_addr,
    input  logic [2:0]         req_esize,
    output logic               txn_valid,
    input  logic               txn_ready,
    output logic [AW-1:0]      txn_base,
    output logic [1:0]         txn_size,
    output logic [NTHR-1:0]    txn_mask,
    output logic               done
);

    state_e             state;
    logic [NTHR-1:0]    pending;
    logic [NTHR*AW-1:0] addr_q;
    logic [2:0]         esize_q;
    logic [IDXW-1:0]    leader_idx;
    logic               leader_any;
    tsize_e             seg;
    tsize_e             size_t;
    logic [AW-1:0]      seg_base;
    logic [3:0]         qmask;
    logic [NTHR-1:0]    served;
    logic               accept;
    logic               req_legal;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign txn_valid = (state == ST_RUN) && leader_any;
    assign done      = (state == ST_RUN) && !leader_any;
    assign seg       = seg_of(esize_q);
    assign txn_mask  = served;
    assign txn_size  = size_t;

    // Sequencer: take a request, retire served threads on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pending <= '0;
            addr_q  <= '0;
            esize_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state   <= ST_RUN;
                        pending <= req_mask;
                        addr_q  <= req_addr;
                        esize_q <= req_esize;
                    end
                end
                default: begin
                    if (done) begin
                        state <= ST_IDLE;
                    end else if (txn_valid && txn_ready) begin
                        pending <= pending & ~served;
                    end
                end
            endcase
        end
    end

    hw_coal_leader #(.NTHR(NTHR)) u_leader (
        .pend (pending),
        .idx  (leader_idx),
        .any  (leader_any)
    );

    hw_coal_match #(.NTHR(NTHR), .AW(AW)) u_match (
        .pend     (pending),
        .addr     (addr_q),
        .esize    (esize_q),
        .seg      (seg),
        .leader   (leader_idx),
        .served   (served),
        .seg_base (seg_base),
        .qmask    (qmask)
    );

    hw_coal_shrink #(.AW(AW)) u_shrink (
        .seg      (seg),
        .seg_base (seg_base),
        .qmask    (qmask),
        .size     (size_t),
        .base     (txn_base)
    );

    // Input legality of an offered request: size code and address alignment.
    always_comb begin
        req_legal = (req_esize <= 3'd4);
        for (int i = 0; i < NTHR; i++) begin
            if (req_mask[i] && ((req_addr[i*AW +: AW] & AW'(ebytes_m1(req_esize))) != '0)) begin
                req_legal = 1'b0;
            end
        end
    end

    a_r3_input_legal: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> req_legal);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!txn_valid && !done));

    a_r2_leader_served: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> txn_mask[leader_idx]);

    a_r4_mask_pending: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_mask & ~pending) == '0));

    a_r4_retired: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ready) |=> ((pending & $past(txn_mask)) == '0));

    a_r7_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_size == 2'd0 && txn_base[4:0] == 5'd0) ||
                       (txn_size == 2'd1 && txn_base[5:0] == 6'd0) ||
                       (txn_size == 2'd2 && txn_base[6:0] == 7'd0)));

    a_r8_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_mask == '0) |=> done);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base) &&
                                       $stable(txn_size) && $stable(txn_mask)));

    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_ready && !done));

endmodule

// File: tb/hw_coalescer_tb.sv
`timescale 1ns/1ps
module hw_coalescer_tb;

    localparam int NT = 16;
    localparam int AW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [NT-1:0]     req_mask = '0;
    logic [NT*AW-1:0]  req_addr = '0;
    logic [2:0]        req_esize = '0;
    logic              txn_valid;
    logic              txn_ready = 1'b0;
    logic [AW-1:0]     txn_base;
    logic [1:0]        txn_size;
    logic [NT-1:0]     txn_mask;
    logic              done;

    always #2 clk = ~clk;

    hw_coalescer #(.NTHR(NT), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_mask(req_mask),
        .req_addr(req_addr), .req_esize(req_esize),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_base(txn_base),
        .txn_size(txn_size), .txn_mask(txn_mask), .done(done)
    );

    int checks = 0;
    int failures = 0;

    logic [31:0] a_tb     [NT];
    logic [31:0] exp_base [NT];
    logic [1:0]  exp_size [NT];
    logic [15:0] exp_mask [NT];
    int          nexp;
    int          got_cnt;
    logic [31:0] got_base0;
    logic [1:0]  got_size0;
    logic [15:0] got_mask0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Reference: leader segment, served set, then halving on min/max byte offsets.
    task automatic ref_model(input logic [15:0] m, input logic [2:0] es);
        logic [15:0] pend;
        logic [15:0] srv;
        logic [31:0] segb, sb, wb, rel, off, last, mn, mx, sz;
        int l;
        pend = m;
        nexp = 0;
        while (pend != 0) begin
            l = 0;
            for (int i = NT - 1; i >= 0; i--) if (pend[i]) l = i;
            segb = 32'd32 << ((es > 3'd2) ? 2 : es);
            sb   = a_tb[l] & ~(segb - 1);
            srv  = '0;
            mn   = 32'hFFFF;
            mx   = 0;
            for (int i = 0; i < NT; i++) begin
                if (pend[i] && ((a_tb[i] & ~(segb - 1)) == sb)) begin
                    srv[i] = 1'b1;
                    off  = a_tb[i] - sb;
                    last = off + (32'd1 << es) - 1;
                    if (off < mn) mn = off;
                    if (last > mx) mx = last;
                end
            end
            sz = segb;
            wb = sb;
            if (sz == 128) begin
                if (mx < 64) sz = 64;
                else if (mn >= 64) begin sz = 64; wb = sb + 64; end
            end
            if (sz == 64) begin
                rel = wb - sb;
                if (mx < rel + 32) sz = 32;
                else if (mn >= rel + 32) begin sz = 32; wb = wb + 32; end
            end
            exp_base[nexp] = wb;
            exp_size[nexp] = (sz == 32) ? 2'd0 : (sz == 64) ? 2'd1 : 2'd2;
            exp_mask[nexp] = srv;
            nexp++;
            pend = pend & ~srv;
        end
    endtask

    task automatic run_req(input logic [15:0] m, input logic [2:0] es, input string tag);
        logic [15:0] srv;
        logic [31:0] hb;
        logic [1:0]  hs;
        logic [15:0] hm;
        bit hold, fin, rdy;
        int k;
        ref_model(m, es);
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_mask  = m;
        req_esize = es;
        for (int i = 0; i < NT; i++) req_addr[i*AW +: AW] = a_tb[i];
        @(negedge clk);
        req_valid = 1'b0;
        req_mask  = '1;
        req_addr  = ~req_addr;
        k = 0; srv = '0; hold = 0; fin = 0;
        hb = '0; hs = '0; hm = '0;
        got_base0 = '0; got_size0 = '0; got_mask0 = '0;
        for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
            if (hold) begin
                check(txn_valid && txn_base == hb && txn_size == hs && txn_mask == hm,
                      "R9 stalled transaction held", txn_base, hb);
                hold = 0;
            end
            if (done) begin
                check(k == nexp, {tag, " transaction count"}, 32'(k), 32'(nexp));
                check(srv == m, "R4 every active thread served", 32'(srv), 32'(m));
                check(!txn_valid, "R10 no transaction with done", 32'(txn_valid), 32'd0);
                if (m == 0) check(cyc == 0, "R8 empty request done at once", 32'(cyc), 32'd0);
                fin = 1;
                txn_ready = 1'b0;
                @(negedge clk);
                check(req_ready && !done, "R10 idle and done dropped", {30'd0, req_ready, done}, 32'd2);
            end else begin
                check(!req_ready, "R1 not ready while busy", 32'(req_ready), 32'd0);
                if (txn_valid) begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    rdy = lfsr[0] | lfsr[3];
                    txn_ready = rdy;
                    if (rdy) begin
                        if (k < nexp) begin
                            check(txn_base == exp_base[k], {tag, " base"}, txn_base, exp_base[k]);
                            check(txn_size == exp_size[k], {tag, " size"}, 32'(txn_size), 32'(exp_size[k]));
                            check(txn_mask == exp_mask[k], {tag, " mask"}, 32'(txn_mask), 32'(exp_mask[k]));
                        end else begin
                            check(1'b0, {tag, " extra transaction"}, 32'(k), 32'(nexp));
                        end
                        check((srv & txn_mask) == 0, "R4 thread served twice", 32'(srv & txn_mask), 32'd0);
                        check((txn_mask & ~m) == 0, "R8 inactive thread served", 32'(txn_mask), 32'(m));
                        if (k == 0) begin
                            got_base0 = txn_base;
                            got_size0 = txn_size;
                            got_mask0 = txn_mask;
                        end
                        srv = srv | txn_mask;
                        k++;
                    end else begin
                        hold = 1;
                        hb = txn_base; hs = txn_size; hm = txn_mask;
                    end
                end else begin
                    txn_ready = 1'b0;
                    check(1'b0, "R9 threads pending but no transaction", 32'd0, 32'd1);
                end
                @(negedge clk);
            end
        end
        txn_ready = 1'b0;
        if (!fin) check(1'b0, "R10 done never raised", 32'd0, 32'd1);
        got_cnt = k;
    endtask

    task automatic set_stride(input logic [31:0] base, input int stride, input logic [2:0] es);
        for (int i = 0; i < NT; i++) a_tb[i] = base + 32'(i * stride) * (32'd1 << es);
    endtask

    initial begin
        repeat (20000 * 9) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] bases [4];
        int          strides [8];
        logic [15:0] masks [5];
        bases   = '{32'h0000_0000, 32'h0000_1040, 32'h0000_2FC0, 32'h0000_7000};
        strides = '{0, 1, 2, 3, 4, 8, 16, 33};
        masks   = '{16'hFFFF, 16'hAAAA, 16'h0FF0, 16'h8001, 16'h0000};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
        check(txn_valid == 1'b0, "R1 reset no transaction", 32'(txn_valid), 32'd0);
        check(done == 1'b0, "R1 reset no done", 32'(done), 32'd0);

        // R3 byte elements, unit stride: one 32-byte transaction
        set_stride(32'h100, 1, 3'd0);
        run_req(16'hFFFF, 3'd0, "R3 byte unit stride");
        check(got_cnt == 1 && got_size0 == 2'd0 && got_base0 == 32'h100, "R3 byte segment 32",
              got_base0, 32'h100);

        // R3 16-byte elements, unit stride: two full 128-byte transactions
        set_stride(32'h1000, 1, 3'd4);
        run_req(16'hFFFF, 3'd4, "R3 wide unit stride");
        check(got_cnt == 2 && got_size0 == 2'd2 && got_base0 == 32'h1000, "R3 wide segment 128",
              32'(got_cnt), 32'd2);

        // R5 word elements on the upper half of a 128-byte segment
        set_stride(32'h340, 1, 3'd2);
        run_req(16'hFFFF, 3'd2, "R5 upper half");
        check(got_cnt == 1 && got_size0 == 2'd1 && got_base0 == 32'h340, "R5 trimmed to upper 64",
              got_base0, 32'h340);

        // R6 cascaded trim: 32 bytes in the top quarter
        set_stride(32'h360, 1, 3'd2);
        run_req(16'h00FF, 3'd2, "R6 top quarter");
        check(got_cnt == 1 && got_size0 == 2'd0 && got_base0 == 32'h360, "R6 trimmed to 32",
              got_base0, 32'h360);

        // R6 half-word elements in the lower half of a 64-byte segment
        set_stride(32'h200, 1, 3'd1);
        run_req(16'hFFFF, 3'd1, "R6 native 64 lower");
        check(got_cnt == 1 && got_size0 == 2'd0 && got_base0 == 32'h200, "R6 native 64 trimmed",
              got_base0, 32'h200);

        // R8 empty request
        set_stride(32'h0, 1, 3'd2);
        run_req(16'h0000, 3'd2, "R8 empty");
        check(got_cnt == 0, "R8 empty issues nothing", 32'(got_cnt), 32'd0);

        // R8 one active thread, the others scattered far away
        for (int i = 0; i < NT; i++) a_tb[i] = 32'h8000 * 32'(i);
        run_req(16'h0001, 3'd2, "R8 single active");
        check(got_cnt == 1 && got_mask0 == 16'h0001 && got_size0 == 2'd0, "R8 inactive ignored",
              32'(got_mask0), 32'h1);

        // R2 leader skips the inactive thread 0
        set_stride(32'h400, 1, 3'd2);
        a_tb[0] = 32'h9000;
        run_req(16'hFFFE, 3'd2, "R2 leader");
        check(got_mask0 == 16'hFFFE && got_base0 == 32'h400, "R2 leader is lowest pending",
              32'(got_mask0), 32'hFFFE);

        // Sweep over size, stride, base and mask patterns
        for (int es = 0; es < 5; es++)
            for (int s = 0; s < 8; s++)
                for (int b = 0; b < 4; b++)
                    for (int mi = 0; mi < 5; mi++) begin
                        set_stride(bases[b] + 32'(b) * (32'd1 << es), strides[s], 3'(es));
                        run_req(masks[mi], 3'(es), "R2/R4/R7 strided sweep");
                    end

        // Scattered addresses with collisions inside segments
        for (int es = 0; es < 5; es++)
            for (int seed = 0; seed < 6; seed++)
                for (int mi = 0; mi < 4; mi++) begin
                    for (int i = 0; i < NT; i++)
                        a_tb[i] = 32'h0002_0000 +
                                  ((((32'(i) * 32'd2654435761) + 32'(seed) * 32'd40503) >> 20) & 32'h3F)
                                  * (32'd1 << es);
                    run_req(masks[mi], 3'(es), "R5/R6/R4 scattered");
                end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule